// File: doc/BRIEF.md
# Section Parity Error Monitor

This block watches a byte-wide receive stream that has already been framed, and checks the section-layer bit-interleaved parity (BIP-8) of every frame. Each valid byte is folded into a running XOR. A frame begins with a byte flagged by the start strobe, and runs up to the byte just before the next start. The first byte of the following frame carries the parity that the far end sent. When that byte arrives, the block compares it against the value it accumulated. The mismatch vector is then turned into an increment for an error counter.

A mode input picks how much each comparison adds. It can add one for any erred frame, or the number of mismatching parity bits (zero to eight). The counter is `CNT_W` bits wide (32 by default) and saturates at all ones. Software reads it one byte at a time. A read of byte 0 captures a snapshot of the whole counter, and reads of the higher bytes return that snapshot. A one-cycle pulse reports each frame whose parity did not match. A loss-of-alignment input discards the frame in progress.

Top module: `sect_bip_mon`

## Requirements
- R1: The expected parity of a frame is the XOR of every accepted byte from its start byte up to the last accepted byte before the next start byte. It is compared bit by bit with the start byte of the next frame.
- R2: A comparison is made only when the previous frame held exactly `FRAME_BYTES` accepted bytes and no loss of alignment occurred since its start. The first frame after reset or after loss of alignment is never compared.
- R3: With `per_frame` = 1, the counter grows by exactly 1 for each comparison that has at least one mismatching bit.
- R4: With `per_frame` = 0, the counter grows by the number of mismatching bits of each comparison (0 to 8).
- R5: The counter saturates at all ones and never wraps.
- R6: `err_pulse` is high for exactly the one cycle after the edge that samples a compared start byte, and only if that comparison mismatched.
- R7: A read is a cycle with `rd_en` high, and `rd_data` holds its result after that edge. Address 0 returns counter bits 7:0 and captures the whole counter as a snapshot. Address a (1 and up) returns snapshot bits 8a+7:8a. The snapshot changes only on an address-0 read.
- R8: When an address-0 read falls in the same cycle as a counter increment, the read and snapshot give the value before the increment. The increment is not lost.
- R9: Bytes with `byte_vld` low, bytes sampled while `lof` is high, and bytes that arrive before the first start byte change neither the parity nor the counter.
- R10: After reset the counter, the snapshot, `rd_data` and `err_pulse` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lof | input | 1 | Loss of frame alignment; discards the frame in progress |
| byte_vld | input | 1 | The byte on `din` is part of the stream this cycle |
| frm_start | input | 1 | The valid byte is the first byte of a frame (the received parity) |
| din | input | 8 | Stream byte |
| per_frame | input | 1 | 1: add one per erred frame; 0: add the number of erred bits |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | RD_AW | Byte index of the counter, 0 = least significant |
| rd_data | output | 8 | Read result, valid the cycle after the read |
| err_pulse | output | 1 | One-cycle flag for a frame with a parity mismatch |

## Verification
An address-0 read and a counter increment can land on the same clock edge. The bench forces this by asserting the read in the cycle right after a mismatching start byte, which is exactly when the increment takes effect. It then expects the read to return the old low byte, and a later full read to show the old value plus the increment. The mismatch pulse and the counter update sit one cycle apart. The bench checks the pulse on every clock against its own frame model, while byte reads run during idle gaps.

// File: rtl/sbip_pkg.sv
package sbip_pkg;

    typedef struct packed {
        logic       chk;
        logic [7:0] mism;
    } sbip_cmp_t;

    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/sbip_accum.sv
module sbip_accum
    import sbip_pkg::*;
#(
    parameter int FRAME_BYTES = 2430
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lof,
    input  logic       byte_vld,
    input  logic       frm_start,
    input  logic [7:0] din,
    output sbip_cmp_t  cmp_o
);

    localparam int CW = $clog2(FRAME_BYTES + 2);
    localparam logic [CW-1:0] FULL = CW'(FRAME_BYTES);
    localparam logic [CW-1:0] OVER = CW'(FRAME_BYTES + 1);

    typedef struct packed {
        logic [7:0]    acc;
        logic [CW-1:0] cnt;
        logic          aligned;
        sbip_cmp_t     cmp;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cmp = '0;
        if (lof) begin
            st_d.aligned = 1'b0;
            st_d.cnt     = '0;
            st_d.acc     = '0;
        end else if (byte_vld) begin
            if (frm_start) begin
                if (st_q.aligned && st_q.cnt == FULL) begin
                    st_d.cmp.chk  = 1'b1;
                    st_d.cmp.mism = din ^ st_q.acc;
                end
                st_d.acc     = din;
                st_d.cnt     = CW'(1);
                st_d.aligned = 1'b1;
            end else if (st_q.aligned) begin
                st_d.acc = st_q.acc ^ din;
                if (st_q.cnt != OVER) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o = st_q.cmp;

    // R2
    cmp_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_o.chk |-> $past(frm_start && byte_vld && !lof));

    // R9
    lof_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lof) |-> !cmp_o.chk);

endmodule

// File: rtl/sbip_errcnt.sv
module sbip_errcnt
    import sbip_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_frame,
    input  sbip_cmp_t        cmp_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t    st_d, st_q;
    logic [3:0] inc;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d = st_q;
        inc  = per_frame ? {3'd0, |cmp_i.mism} : ones8(cmp_i.mism);
        sum  = {1'b0, st_q.cnt} + (CNT_W + 1)'(inc);
        if (cmp_i.chk) begin
            st_d.cnt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R5
    sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_o) == CNT_MAX |-> cnt_o == CNT_MAX);

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o >= $past(cnt_o)) && ((cnt_o - $past(cnt_o)) <= CNT_W'(8)));

    // R3
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(per_frame) |-> (cnt_o - $past(cnt_o)) <= CNT_W'(1));

endmodule

// File: rtl/sbip_rdport.sv
module sbip_rdport #(
    parameter int CNT_W  = 32,
    parameter int NBYTES = 4,
    parameter int AW     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [7:0]       rd_data
);

    localparam int SW = NBYTES * 8;

    typedef struct packed {
        logic [SW-1:0] snap;
        logic [7:0]    rdata;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [SW-1:0] cnt_ext;
    logic [7:0]    lane [NBYTES];

    assign cnt_ext = SW'(cnt_i);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = st_q.snap[g*8 +: 8];
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (rd_addr == '0) begin
                st_d.rdata = cnt_ext[7:0];
                st_d.snap  = cnt_ext;
            end else if (int'(rd_addr) < NBYTES) begin
                st_d.rdata = lane[rd_addr];
            end else begin
                st_d.rdata = 8'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en && rd_addr == '0) |-> $stable(st_q.snap));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));

endmodule

// File: rtl/sect_bip_mon.sv
module sect_bip_mon
    import sbip_pkg::*;
#(
    parameter int FRAME_BYTES = 2430,
    parameter int CNT_W       = 32,
    parameter int RD_AW       = (((CNT_W + 7) / 8) > 1) ? $clog2((CNT_W + 7) / 8) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lof,
    input  logic             byte_vld,
    input  logic             frm_start,
    input  logic [7:0]       din,
    input  logic             per_frame,
    input  logic             rd_en,
    input  logic [RD_AW-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic             err_pulse
);

    localparam int NBYTES = (CNT_W + 7) / 8;

    sbip_cmp_t        cmp;
    logic [CNT_W-1:0] cnt;

    sbip_accum #(.FRAME_BYTES(FRAME_BYTES)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .lof       (lof),
        .byte_vld  (byte_vld),
        .frm_start (frm_start),
        .din       (din),
        .cmp_o     (cmp)
    );

    sbip_errcnt #(.CNT_W(CNT_W)) u_errcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_frame (per_frame),
        .cmp_i     (cmp),
        .cnt_o     (cnt)
    );

    sbip_rdport #(.CNT_W(CNT_W), .NBYTES(NBYTES), .AW(RD_AW)) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .cnt_i   (cnt),
        .rd_data (rd_data)
    );

    assign err_pulse = cmp.chk && (cmp.mism != 8'd0);

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R6
    pulse_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> cnt != $past(cnt) || cnt == {CNT_W{1'b1}});

endmodule

// File: tb/sim_sect_bip_mon.sv
module sim_sect_bip_mon;

    localparam int FB = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lof = 1'b0;
    logic       byte_vld = 1'b0;
    logic       frm_start = 1'b0;
    logic [7:0] din = 8'd0;
    logic       per_frame = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data0, rd_data1;
    logic       err0, err1;

    always #2.5 clk = ~clk;

    sect_bip_mon #(.FRAME_BYTES(FB)) u0 (
        .clk(clk), .rst_n(rst_n), .lof(lof), .byte_vld(byte_vld),
        .frm_start(frm_start), .din(din), .per_frame(per_frame),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data0), .err_pulse(err0)
    );

    sect_bip_mon #(.FRAME_BYTES(FB), .CNT_W(10)) u1 (
        .clk(clk), .rst_n(rst_n), .lof(lof), .byte_vld(byte_vld),
        .frm_start(frm_start), .din(din), .per_frame(per_frame),
        .rd_en(rd_en), .rd_addr(rd_addr[0:0]), .rd_data(rd_data1), .err_pulse(err1)
    );

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    logic   exp_pulse = 1'b0;
    logic [7:0] prev_par = 8'd0;
    bit     prev_ok = 1'b0;
    longint exp0 = 0;
    longint exp1 = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R6: pulse compared with the model on every clock
    always begin
        logic e;
        @(posedge clk);
        e = exp_pulse;
        #1;
        if (rst_n && !done) begin
            chk(err0 == e, "R6 pulse u0", longint'(err0), longint'(e));
            chk(err1 == e, "R6 pulse u1", longint'(err1), longint'(e));
        end
    end

    task automatic model_add(input logic [7:0] m);
        longint inc;
        inc = per_frame ? longint'(m != 8'd0) : longint'($countones(m));
        exp0 = exp0 + inc;
        if (exp0 > 64'hFFFF_FFFF) exp0 = 64'hFFFF_FFFF;
        exp1 = exp1 + inc;
        if (exp1 > 1023) exp1 = 1023;
    endtask

    task automatic idle();
        @(negedge clk);
        byte_vld = 1'b0; frm_start = 1'b0; lof = 1'b0; rd_en = 1'b0;
        din = 8'($urandom); exp_pulse = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] flip, input bit mid_read);
        logic [7:0] acc, b, m;
        longint old0;
        acc = 8'd0;
        old0 = exp0;
        for (int i = 0; i < n; i++) begin
            if (i % 5 == 3) begin
                // R9: gap byte with start strobe but no valid
                @(negedge clk);
                byte_vld = 1'b0; frm_start = 1'b1; din = 8'($urandom);
                exp_pulse = 1'b0; rd_en = 1'b0;
            end
            @(negedge clk);
            rd_en = mid_read && (i == 1);
            rd_addr = 2'd0;
            if (i == 0) begin
                b = prev_ok ? (prev_par ^ flip) : 8'($urandom);
                m = b ^ prev_par;
                old0 = exp0;
                exp_pulse = prev_ok && (m != 8'd0);
                if (prev_ok) model_add(m);
                acc = b;
            end else begin
                b = 8'($urandom);
                acc = acc ^ b;
                exp_pulse = 1'b0;
            end
            byte_vld = 1'b1; frm_start = (i == 0); din = b;
            if (mid_read && i == 1) begin
                @(posedge clk);
                #1;
                chk(rd_data0 == old0[7:0], "R8 collided read low byte", longint'(rd_data0), old0 & 255);
            end
        end
        idle();
        prev_par = acc;
        prev_ok = (n == FB);
    endtask

    task automatic read_all(input string req);
        logic [31:0] v0;
        logic [15:0] v1;
        @(negedge clk);
        byte_vld = 1'b0; frm_start = 1'b0; exp_pulse = 1'b0;
        rd_en = 1'b1; rd_addr = 2'd0;
        @(posedge clk); #1;
        v0[7:0] = rd_data0; v1[7:0] = rd_data1;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            rd_addr = 2'(k);
            @(posedge clk); #1;
            v0[k*8 +: 8] = rd_data0;
            if (k == 1) v1[15:8] = rd_data1;
        end
        @(negedge clk);
        rd_en = 1'b0;
        chk(v0 == 32'(exp0), req, longint'(v0), exp0);
        chk(v1 == 16'(exp1), req, longint'(v1), exp1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(rd_data0 == 8'd0, "R10 rd_data after reset", longint'(rd_data0), 0);
        chk(err0 == 1'b0, "R10 err_pulse after reset", longint'(err0), 0);
        rst_n = 1'b1;
        read_all("R10 counter after reset");

        // R9: valid bytes before any start byte
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; frm_start = 1'b0; din = 8'($urandom);
        end
        idle();

        per_frame = 1'b0;
        send_frame(FB, 8'h00, 1'b0);
        read_all("R2 first frame not compared");
        send_frame(FB, 8'h00, 1'b0);
        read_all("R1 matching parity");
        send_frame(FB, 8'h01, 1'b0);
        read_all("R4 one bit");
        send_frame(FB, 8'hA5, 1'b0);
        read_all("R4 four bits");

        per_frame = 1'b1;
        send_frame(FB, 8'h7E, 1'b0);
        read_all("R3 per-frame six bits");
        send_frame(FB, 8'h00, 1'b0);
        read_all("R3 per-frame clean");

        send_frame(FB - 2, 8'h00, 1'b0);
        send_frame(FB, 8'hFF, 1'b0);
        read_all("R2 after short frame");
        send_frame(FB, 8'h0F, 1'b0);
        read_all("R3 after recovery");

        send_frame(FB + 1, 8'h00, 1'b0);
        send_frame(FB, 8'hFF, 1'b0);
        read_all("R2 after long frame");

        // R9: loss of alignment
        @(negedge clk);
        lof = 1'b1; byte_vld = 1'b1; frm_start = 1'b1; din = 8'($urandom);
        exp_pulse = 1'b0;
        idle();
        prev_ok = 1'b0;
        send_frame(FB, 8'hFF, 1'b0);
        read_all("R9 first frame after lof");
        send_frame(FB, 8'h03, 1'b0);
        read_all("R1 compare after lof recovery");

        per_frame = 1'b0;
        send_frame(FB, 8'h11, 1'b1);
        read_all("R8 increment kept after collision");

        for (int f = 0; f < 130; f++) begin
            send_frame(FB, 8'hFF, 1'b0);
        end
        read_all("R5 saturation reached");
        send_frame(FB, 8'hFF, 1'b0);
        read_all("R5 saturation holds");
        chk(exp1 == 1023, "R5 model at limit", exp1, 1023);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule